// File: doc/BRIEF.md
# Pulsed Feed-Forward Correction Player

This block replays a stored I/Q correction waveform once per RF pulse in a digital field control loop that runs at 40 MHz. The host loads the waveform into one of two table banks through a simple write port. On the rising edge of the RF gate, the block latches the bank to play and the step length. It then walks the table from entry 0, holding each entry for 8 clock cycles (200 ns) or 16 clock cycles (400 ns). When it reaches the last entry it stays there until the gate drops.

Each entry is a signed 8-bit I value and a signed 8-bit Q value. The block sign-extends the selected entry, adds it to the controller's 16-bit I/Q output, and clamps the sum to the 16-bit range, so the result can drive the RF output directly. When the gate is low, or when the global enable is low, the correction is zero and the controller output passes through with one cycle of delay. The host can rewrite the idle bank at any time and switch to it. The new contents take effect at the next pulse. Writes aimed at the bank that is currently playing are dropped until the pulse ends.

Top module: `ffp_player`

## Requirements
- R1: While reset is high and on the first cycle after it, both drive outputs are 0. No correction is applied until a gate rising edge has been seen.
- R2: If the gate is first sampled high at clock edge k, then from edge k+2 the drive output equals the clamped sum of the loop input (sampled one edge earlier) and table entry 0 of the latched bank.
- R3: With the step select at 0 when the pulse starts, entry n is applied to the outputs registered at edges k+2+8n through k+9+8n.
- R4: With the step select at 1 when the pulse starts, each entry is held for 16 cycles. A change of step select during a pulse has no effect until the next pulse.
- R5: After the last table entry is reached, it stays applied until the gate falls. The index never wraps to entry 0.
- R6: Once the gate has been sampled low at edge f, outputs registered from edge f+2 onward carry no correction: the drive equals the loop input from one cycle earlier.
- R7: When the enable input is sampled low, the registered drive equals the loop input with no correction. Host writes are still stored while enable is low.
- R8: The bank select (0 or 1) is sampled at the pulse start. Changing it during a pulse does not alter that pulse's playback, and the new bank plays from the next pulse.
- R9: A host write to the bank that is playing, made while the gate pulse is active, is discarded. A write to the other bank during the pulse is stored.
- R10: The sum saturates: results above 32767 give 32767, and results below -32768 give -32768, independently on I and Q.
- R11: Table entries are two's complement. Bit 7 set means negative, so 8'h80 adds -128 and 8'h7F adds +127.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Loop clock (40 MHz) |
| rst | input | 1 | Synchronous active-high reset |
| ff_en | input | 1 | Global correction enable; 0 forces zero correction |
| rf_gate | input | 1 | RF pulse gate; its rising edge starts playback |
| step_sel | input | 1 | Hold per entry: 0 = 8 cycles, 1 = 16 cycles (latched at pulse start) |
| bank_sel | input | 1 | Bank to play at the next pulse start |
| wr_en | input | 1 | Host table write strobe |
| wr_bank | input | 1 | Bank addressed by the host write |
| wr_addr | input | ADDR_W | Entry index of the host write |
| wr_i | input | DW | Signed I value to store |
| wr_q | input | DW | Signed Q value to store |
| loop_i | input | OW | Controller I output |
| loop_q | input | OW | Controller Q output |
| drive_i | output | OW | Corrected, saturated I drive (registered) |
| drive_q | output | OW | Corrected, saturated Q drive (registered) |

## Verification
The bench tracks the exact cycle at which each entry first appears. An off-by-one in the two-stage read pipeline, or in the hold counter, would show up as entries changing one cycle early or late for both the 8-cycle and 16-cycle steps. Long pulses drive the index past the end of the table, so a design that wraps to entry 0 or runs past the last entry would apply the wrong correction. Mid-pulse changes of bank select and mid-pulse writes to both banks expose a design that switches banks immediately or lets the host corrupt the waveform being played. Loop values near full scale, with extreme entries of both signs, catch a missing clamp that would wrap around, and catch zero-extension of negative entries.

// File: rtl/ffp_pkg.sv
package ffp_pkg;

  typedef enum logic {
    HOLD_SHORT = 1'b0,
    HOLD_LONG  = 1'b1
  } hold_mode_e;

  localparam int unsigned NUM_BANKS = 2;

endpackage

// File: rtl/ffp_bank_ram.sv
module ffp_bank_ram #(
  parameter int unsigned AW = 12,
  parameter int unsigned W  = 16
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);

  localparam int unsigned DEPTH = 1 << AW;

  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      mem[waddr] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/ffp_sequencer.sv
module ffp_sequencer #(
  parameter int unsigned ADDR_W     = 12,
  parameter int unsigned SHORT_HOLD = 8,
  parameter int unsigned LONG_HOLD  = 16,
  parameter int unsigned CNT_W      = $clog2(LONG_HOLD)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rf_gate,
  input  logic              step_sel,
  input  logic              bank_sel,
  output logic              playing,
  output logic [ADDR_W-1:0] rd_idx,
  output logic [CNT_W-1:0]  step_cnt,
  output logic [CNT_W-1:0]  step_last,
  output logic              play_bank
);
  import ffp_pkg::*;

  localparam logic [ADDR_W-1:0] LAST_IDX   = {ADDR_W{1'b1}};
  localparam logic [CNT_W-1:0]  SHORT_LAST = CNT_W'(SHORT_HOLD - 1);
  localparam logic [CNT_W-1:0]  LONG_LAST  = CNT_W'(LONG_HOLD - 1);

  hold_mode_e mode_req;
  logic       start;
  logic       step_done;

  assign mode_req  = hold_mode_e'(step_sel);
  assign start     = rf_gate && !playing;
  assign step_done = (step_cnt == step_last);

  always_ff @(posedge clk) begin
    if (rst) begin
      playing   <= 1'b0;
      rd_idx    <= '0;
      step_cnt  <= '0;
      step_last <= SHORT_LAST;
      play_bank <= 1'b0;
    end else if (start) begin
      playing   <= 1'b1;
      rd_idx    <= '0;
      step_cnt  <= '0;
      step_last <= (mode_req == HOLD_LONG) ? LONG_LAST : SHORT_LAST;
      play_bank <= bank_sel;
    end else if (!rf_gate) begin
      playing  <= 1'b0;
      step_cnt <= '0;
    end else begin
      if (step_done) begin
        step_cnt <= '0;
        if (rd_idx != LAST_IDX) begin
          rd_idx <= rd_idx + 1'b1;
        end
      end else begin
        step_cnt <= step_cnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/ffp_out_stage.sv
module ffp_out_stage #(
  parameter int unsigned DW = 8,
  parameter int unsigned OW = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 apply,
  input  logic [DW-1:0]        ent_i,
  input  logic [DW-1:0]        ent_q,
  input  logic signed [OW-1:0] loop_i,
  input  logic signed [OW-1:0] loop_q,
  output logic signed [OW-1:0] drive_i,
  output logic signed [OW-1:0] drive_q
);

  localparam int unsigned EXT = OW - DW + 1;
  localparam logic signed [OW-1:0] POS_MAX = {1'b0, {(OW-1){1'b1}}};
  localparam logic signed [OW-1:0] NEG_MAX = {1'b1, {(OW-1){1'b0}}};

  logic [DW-1:0] corr [2];
  logic [OW-1:0] base [2];
  logic [OW-1:0] res  [2];

  assign corr[0] = apply ? ent_i : '0;
  assign corr[1] = apply ? ent_q : '0;
  assign base[0] = loop_i;
  assign base[1] = loop_q;

  for (genvar c = 0; c < 2; c++) begin : g_lane
    logic [OW:0] sum;
    assign sum = {base[c][OW-1], base[c]} + {{EXT{corr[c][DW-1]}}, corr[c]};
    always_comb begin
      if (sum[OW] != sum[OW-1]) begin
        res[c] = sum[OW] ? NEG_MAX : POS_MAX;
      end else begin
        res[c] = sum[OW-1:0];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      drive_i <= '0;
      drive_q <= '0;
    end else begin
      drive_i <= res[0];
      drive_q <= res[1];
    end
  end

endmodule

// File: rtl/ffp_player.sv
module ffp_player #(
  parameter int unsigned ADDR_W     = 12,
  parameter int unsigned DW         = 8,
  parameter int unsigned OW         = 16,
  parameter int unsigned SHORT_HOLD = 8,
  parameter int unsigned LONG_HOLD  = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 ff_en,
  input  logic                 rf_gate,
  input  logic                 step_sel,
  input  logic                 bank_sel,
  input  logic                 wr_en,
  input  logic                 wr_bank,
  input  logic [ADDR_W-1:0]    wr_addr,
  input  logic [DW-1:0]        wr_i,
  input  logic [DW-1:0]        wr_q,
  input  logic signed [OW-1:0] loop_i,
  input  logic signed [OW-1:0] loop_q,
  output logic signed [OW-1:0] drive_i,
  output logic signed [OW-1:0] drive_q
);
  import ffp_pkg::*;

  localparam int unsigned CNT_W = $clog2(LONG_HOLD);
  localparam int unsigned EW    = 2 * DW;

  logic              playing;
  logic [ADDR_W-1:0] rd_idx;
  logic [CNT_W-1:0]  step_cnt;
  logic [CNT_W-1:0]  step_last;
  logic              play_bank;
  logic              read_valid;
  logic [EW-1:0]     bank_rd [NUM_BANKS];
  logic [EW-1:0]     entry;

  ffp_sequencer #(
    .ADDR_W    (ADDR_W),
    .SHORT_HOLD(SHORT_HOLD),
    .LONG_HOLD (LONG_HOLD),
    .CNT_W     (CNT_W)
  ) u_seq (
    .clk      (clk),
    .rst      (rst),
    .rf_gate  (rf_gate),
    .step_sel (step_sel),
    .bank_sel (bank_sel),
    .playing  (playing),
    .rd_idx   (rd_idx),
    .step_cnt (step_cnt),
    .step_last(step_last),
    .play_bank(play_bank)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic bank_we;
    logic locked;
    assign locked  = playing && (play_bank == 1'(b));
    assign bank_we = wr_en && (wr_bank == 1'(b)) && !locked;

    ffp_bank_ram #(
      .AW(ADDR_W),
      .W (EW)
    ) u_ram (
      .clk  (clk),
      .we   (bank_we),
      .waddr(wr_addr),
      .wdata({wr_i, wr_q}),
      .raddr(rd_idx),
      .rdata(bank_rd[b])
    );
  end

  assign entry = bank_rd[play_bank];

  always_ff @(posedge clk) begin
    if (rst) begin
      read_valid <= 1'b0;
    end else begin
      read_valid <= playing;
    end
  end

  ffp_out_stage #(
    .DW(DW),
    .OW(OW)
  ) u_out (
    .clk    (clk),
    .rst    (rst),
    .apply  (read_valid && ff_en),
    .ent_i  (entry[EW-1:DW]),
    .ent_q  (entry[DW-1:0]),
    .loop_i (loop_i),
    .loop_q (loop_q),
    .drive_i(drive_i),
    .drive_q(drive_q)
  );

endmodule

// File: rtl/ffp_player_chk.sv
module ffp_player_chk #(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned OW     = 16,
  parameter int unsigned CNT_W  = 4
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 ff_en,
  input logic                 rf_gate,
  input logic                 bank_sel,
  input logic signed [OW-1:0] loop_i,
  input logic signed [OW-1:0] loop_q,
  input logic signed [OW-1:0] drive_i,
  input logic signed [OW-1:0] drive_q,
  input logic                 playing,
  input logic [ADDR_W-1:0]    rd_idx,
  input logic [CNT_W-1:0]     step_cnt,
  input logic [CNT_W-1:0]     step_last,
  input logic                 play_bank
);

  AST_RESET_ZERO: assert property (@(posedge clk) $past(rst) |-> (drive_i == '0 && drive_q == '0)); // R1

  AST_START_AT_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rf_gate && !playing) |=> (rd_idx == '0 && step_cnt == '0)); // R2

  AST_STEP_ON_BOUNDARY: assert property (@(posedge clk) disable iff (rst)
    (playing && $past(playing) && rd_idx != $past(rd_idx)) |-> ($past(step_cnt) == $past(step_last))); // R3

  AST_HOLD_LATCHED: assert property (@(posedge clk) disable iff (rst)
    (playing && $past(playing)) |-> $stable(step_last)); // R4

  AST_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
    (playing && $past(playing)) |-> (rd_idx >= $past(rd_idx))); // R5

  AST_IDLE_PASS: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(rf_gate, 3)) |-> (drive_i == $past(loop_i) && drive_q == $past(loop_q))); // R6

  AST_DISABLED_PASS: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(ff_en)) |-> (drive_i == $past(loop_i) && drive_q == $past(loop_q))); // R7

  AST_BANK_LATCHED: assert property (@(posedge clk) disable iff (rst)
    (playing && $past(playing)) |-> $stable(play_bank)); // R8

  AST_BANK_TAKEN: assert property (@(posedge clk) disable iff (rst)
    (rf_gate && !playing) |=> (play_bank == $past(bank_sel))); // R8

endmodule

bind ffp_player ffp_player_chk #(
  .ADDR_W(ADDR_W),
  .OW    (OW),
  .CNT_W (CNT_W)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .ff_en    (ff_en),
  .rf_gate  (rf_gate),
  .bank_sel (bank_sel),
  .loop_i   (loop_i),
  .loop_q   (loop_q),
  .drive_i  (drive_i),
  .drive_q  (drive_q),
  .playing  (playing),
  .rd_idx   (rd_idx),
  .step_cnt (step_cnt),
  .step_last(step_last),
  .play_bank(play_bank)
);

// File: tb/ffp_player_test.sv
module ffp_player_test;

  localparam int CLK_PERIOD = 10;
  localparam int AW    = 4;
  localparam int N_ENT = 1 << AW;
  localparam int SHORT = 8;
  localparam int LONG  = 16;

  logic              clk = 1'b0;
  logic              rst;
  logic              ff_en;
  logic              rf_gate;
  logic              step_sel;
  logic              bank_sel;
  logic              wr_en;
  logic              wr_bank;
  logic [AW-1:0]     wr_addr;
  logic [7:0]        wr_i;
  logic [7:0]        wr_q;
  logic signed [15:0] loop_i;
  logic signed [15:0] loop_q;
  logic signed [15:0] drive_i;
  logic signed [15:0] drive_q;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  logic signed [7:0] m_i [2][N_ENT];
  logic signed [7:0] m_q [2][N_ENT];

  always #(CLK_PERIOD/2) clk = ~clk;

  ffp_player #(
    .ADDR_W(AW), .DW(8), .OW(16), .SHORT_HOLD(SHORT), .LONG_HOLD(LONG)
  ) uut (
    .clk(clk), .rst(rst), .ff_en(ff_en), .rf_gate(rf_gate), .step_sel(step_sel),
    .bank_sel(bank_sel), .wr_en(wr_en), .wr_bank(wr_bank), .wr_addr(wr_addr),
    .wr_i(wr_i), .wr_q(wr_q), .loop_i(loop_i), .loop_q(loop_q),
    .drive_i(drive_i), .drive_q(drive_q)
  );

  function automatic logic signed [15:0] sat_add(input logic signed [15:0] l, input logic signed [7:0] e);
    int s;
    s = int'(l) + int'(e);
    if (s > 32767) s = 32767;
    if (s < -32768) s = -32768;
    return 16'(s);
  endfunction

  task automatic check(input string tag, input int cyc,
                       input logic signed [15:0] ei, input logic signed [15:0] eq);
    n_cmp++;
    if (drive_i !== ei || drive_q !== eq) begin
      n_bad++;
      $display("FAIL %s cycle %0d: drive=(%0d,%0d) expected (%0d,%0d)",
               tag, cyc, drive_i, drive_q, ei, eq);
    end
  endtask

  task automatic host_write(input bit b, input int a, input logic signed [7:0] vi,
                            input logic signed [7:0] vq);
    @(negedge clk);
    wr_en = 1'b1; wr_bank = b; wr_addr = AW'(a); wr_i = vi; wr_q = vq;
    m_i[b][a] = vi; m_q[b][a] = vq;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // One pulse: gate first sampled high at edge k, held for 'hold' edges.
  task automatic play(input string tag, input bit b, input bit lng, input bit en_v,
                      input logic signed [15:0] li, input logic signed [15:0] lq,
                      input int hold, input bit flip_sel, input bit prot_wr);
    int step;
    int mid;
    step = lng ? LONG : SHORT;
    mid  = 5;
    @(negedge clk);
    ff_en = en_v; loop_i = li; loop_q = lq;
    bank_sel = b; step_sel = lng; rf_gate = 1'b1;
    for (int j = 0; j <= hold + 4; j++) begin
      logic signed [15:0] ei;
      logic signed [15:0] eq;
      @(posedge clk);
      @(negedge clk);
      ei = li; eq = lq;
      if (en_v && j >= 2 && j <= hold + 1) begin
        int n;
        n = (j - 2) / step;
        if (n > N_ENT - 1) n = N_ENT - 1;
        ei = sat_add(li, m_i[b][n]);
        eq = sat_add(lq, m_q[b][n]);
      end
      check(tag, j, ei, eq);
      if (j == hold - 1) rf_gate = 1'b0;
      if (flip_sel && j == mid) begin
        bank_sel = ~b;
        step_sel = ~lng;
      end
      if (prot_wr && j == mid) begin
        wr_en = 1'b1; wr_bank = b; wr_addr = AW'(N_ENT - 1); wr_i = 8'sd1; wr_q = 8'sd1;
      end
      if (prot_wr && j == mid + 1) begin
        wr_en = 1'b1; wr_bank = ~b; wr_addr = AW'(N_ENT - 1); wr_i = 8'sd2; wr_q = 8'sd2;
        m_i[~b][N_ENT-1] = 8'sd2; m_q[~b][N_ENT-1] = 8'sd2;
      end
      if (prot_wr && j == mid + 2) wr_en = 1'b0;
    end
  endtask

  task automatic t_reset;
    rst = 1'b1; ff_en = 1'b1; rf_gate = 1'b0; step_sel = 1'b0; bank_sel = 1'b0;
    wr_en = 1'b0; wr_bank = 1'b0; wr_addr = '0; wr_i = '0; wr_q = '0;
    loop_i = 16'sd1234; loop_q = -16'sd77;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 in reset", 0, 16'sd0, 16'sd0);
    rst = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check("R1 after reset", 1, 16'sd1234, -16'sd77);
  endtask

  task automatic t_load;
    for (int n = 0; n < N_ENT; n++) begin
      host_write(1'b0, n, 8'(n * 17 - 120), 8'(100 - n * 13));
      host_write(1'b1, n, 8'(60 - n * 8), 8'(n * 5 - 40));
    end
    host_write(1'b0, N_ENT - 1, 8'sh7F, 8'sh80);
  endtask

  task automatic t_short;
    play("R2/R3/R5/R11 short hold", 1'b0, 1'b0, 1'b1, 16'sd1000, -16'sd2000,
         N_ENT * SHORT + 10, 1'b0, 1'b0);
  endtask

  task automatic t_long;
    play("R4/R6 long hold", 1'b1, 1'b1, 1'b1, -16'sd300, 16'sd400,
         N_ENT * LONG + 6, 1'b0, 1'b0);
  endtask

  task automatic t_disable;
    play("R7 disabled", 1'b0, 1'b0, 1'b0, 16'sd50, 16'sd60, 40, 1'b0, 1'b0);
    ff_en = 1'b0;
    host_write(1'b0, 0, -8'sd99, 8'sd88);
    play("R7 write while disabled", 1'b0, 1'b0, 1'b1, 16'sd50, 16'sd60, 20, 1'b0, 1'b0);
  endtask

  task automatic t_bank;
    play("R8/R4 select change mid-pulse", 1'b0, 1'b0, 1'b1, 16'sd7, -16'sd7, 40, 1'b1, 1'b0);
    play("R8 next pulse bank", 1'b1, 1'b1, 1'b1, 16'sd7, -16'sd7, 40, 1'b0, 1'b0);
  endtask

  task automatic t_protect;
    play("R9 write during pulse", 1'b0, 1'b0, 1'b1, 16'sd0, 16'sd0,
         N_ENT * SHORT + 4, 1'b0, 1'b1);
    play("R9 other bank stored", 1'b1, 1'b0, 1'b1, 16'sd0, 16'sd0,
         N_ENT * SHORT + 4, 1'b0, 1'b0);
    play("R9 playing bank kept", 1'b0, 1'b0, 1'b1, 16'sd0, 16'sd0,
         N_ENT * SHORT + 4, 1'b0, 1'b0);
  endtask

  task automatic t_sat;
    host_write(1'b1, 0, 8'sh7F, 8'sh80);
    play("R10 clamp high/low", 1'b1, 1'b0, 1'b1, 16'sd32700, -16'sd32700, 6, 1'b0, 1'b0);
    host_write(1'b1, 0, 8'sh80, 8'sh7F);
    play("R10 clamp low/high", 1'b1, 1'b0, 1'b1, -16'sd32700, 16'sd32700, 6, 1'b0, 1'b0);
    play("R10 R11 no clamp near edge", 1'b1, 1'b0, 1'b1, -16'sd32640, 16'sd32640, 6, 1'b0, 1'b0);
  endtask

  initial begin
    t_reset();
    t_load();
    t_short();
    t_long();
    t_disable();
    t_bank();
    t_protect();
    t_sat();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule